// File: doc/BRIEF.md
# Width-Selectable Arithmetic/Logic Unit with Status Flags

This block is the arithmetic and logic slice of a datapath. Each cycle it takes two 32-bit operands, an operation code and an operand size, and produces a result at 8, 16 or 32 bits. It reads only the low byte, low half or full word of each operand, just as a program reads the sub-registers of a wide register.

The result is combinational and always reflects the current inputs. Six status flags are held in a register that loads on the rising clock edge when the unit is enabled and the operation code is a defined one. The flags are carry (or borrow), signed overflow, sign, zero, carry out of bit 3, and even parity of the low result byte. A surrounding pipeline uses the flags to make branch or condition decisions one cycle after the operation.

Top module: `mw_alu_flags`

## Requirements
- R1: With `op_sel` = 0 (add), `res` equals the sum of the two operands taken at the active width, truncated to that width.
- R2: With `op_sel` = 1 (subtract), `res` equals `opa - opb` at the active width, truncated to that width.
- R3: With `op_sel` = 2, 3 or 4, `res` is the bitwise AND, OR or XOR respectively of the operands at the active width.
- R4: `width_sel` = 0 selects 8 bits, 1 selects 16 bits, and 2 or 3 select 32 bits. Result bits above the active width are always 0.
- R5: The carry flag, `stat[0]`, is set after an add whose unsigned sum does not fit the active width, or after a subtract whose unsigned `opb` exceeds `opa`.
- R6: The overflow flag, `stat[5]`, is set after an add or subtract whose signed result does not fit the active width.
- R7: The sign flag, `stat[4]`, equals the top bit of the result at the active width.
- R8: The zero flag, `stat[3]`, is set when the result at the active width is all zeros.
- R9: The auxiliary flag, `stat[2]`, is set after an add that carries out of bit 3 into bit 4, or after a subtract that borrows into bit 3.
- R10: The parity flag, `stat[1]`, is set when bits 7:0 of the result hold an even number of ones, whatever the width.
- R11: The bitwise operations clear the carry, overflow and auxiliary flags.
- R12: While `en` is low, `stat` holds its value. Operation codes 5 to 7 give `res` = 0 and leave `stat` unchanged even when `en` is high.
- R13: `stat` updates on the rising clock edge after the operation is presented, and reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Allows the status register to load |
| op_sel | input | 3 | Operation code |
| width_sel | input | 2 | Operand width select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| res | output | 32 | Combinational result, zero-extended |
| stat | output | 6 | Registered flags: [5] overflow, [4] sign, [3] zero, [2] auxiliary, [1] parity, [0] carry |

## Verification
An error in the shared adder shows at once on `res`. The same error reaches `stat` on the next rising edge, because the flags hold no history beyond the previous operation. A status register that loads when it should hold is only visible in a later cycle. The bench therefore follows each disabled or undefined operation with a check of the flags one cycle later, chosen so that the held value differs from the value a wrong load would produce. Width errors show up only when the upper operand bits are non-zero, so the operands carry data above the active width.

// File: rtl/mwalu_pkg.sv
package mwalu_pkg;
  localparam int DW = 32;
  localparam int NFLAG = 6;
  localparam int IW = 6;

  // operation codes
  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_AND = 3'd2;
  localparam logic [2:0] OPC_OR  = 3'd3;
  localparam logic [2:0] OPC_XOR = 3'd4;

  // flag bit positions
  localparam int FB_C = 0;
  localparam int FB_P = 1;
  localparam int FB_A = 2;
  localparam int FB_Z = 3;
  localparam int FB_S = 4;
  localparam int FB_O = 5;

  function automatic logic [DW-1:0] width_mask(input logic [1:0] wsel);
    case (wsel)
      2'd0:    width_mask = 32'h0000_00FF;
      2'd1:    width_mask = 32'h0000_FFFF;
      default: width_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [IW-1:0] width_msb(input logic [1:0] wsel);
    case (wsel)
      2'd0:    width_msb = 6'd7;
      2'd1:    width_msb = 6'd15;
      default: width_msb = 6'd31;
    endcase
  endfunction

  function automatic logic even_par8(input logic [7:0] v);
    even_par8 = ~(^v);
  endfunction
endpackage

// File: rtl/mwalu_adder.sv
module mwalu_adder
  import mwalu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0]  a_m,
  input  logic [W-1:0]  b_m,
  input  logic [W-1:0]  mask,
  input  logic [IW-1:0] msb,
  input  logic          sub,
  output logic [W-1:0]  sum,
  output logic          cy,
  output logic          ov,
  output logic          ax
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic         cout;
  logic         sa, sb, sr;

  always_comb begin
    b_eff = sub ? (~b_m & mask) : b_m;
    full  = {1'b0, a_m} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    cout  = full[msb + 6'd1];
    sum   = full[W-1:0] & mask;
    cy    = sub ? ~cout : cout;
    sa    = a_m[msb];
    sb    = b_m[msb];
    sr    = sum[msb];
    ov    = sub ? ((sa != sb) && (sr != sa)) : ((sa == sb) && (sr != sa));
    ax    = a_m[4] ^ b_m[4] ^ sum[4];
  end
endmodule

// File: rtl/mwalu_logic.sv
module mwalu_logic
  import mwalu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a_m,
  input  logic [W-1:0] b_m,
  output logic [W-1:0] y
);
  always_comb begin
    case (op)
      OPC_AND: y = a_m & b_m;
      OPC_OR:  y = a_m | b_m;
      OPC_XOR: y = a_m ^ b_m;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mwalu_flagreg.sv
module mwalu_flagreg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/mw_alu_flags.sv
module mw_alu_flags
  import mwalu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       op_sel,
  input  logic [1:0]       width_sel,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  output logic [DW-1:0]    res,
  output logic [NFLAG-1:0] stat
);
  logic [DW-1:0]    mask;
  logic [IW-1:0]    msb;
  logic [DW-1:0]    a_m, b_m;
  logic [DW-1:0]    add_y, log_y;
  logic             add_c, add_o, add_a;
  logic             op_is_arith, op_is_logic, op_valid;
  logic             flag_load;
  logic             res_msb, res_zero;
  logic [NFLAG-1:0] nxt_flags;

  always_comb begin
    mask        = width_mask(width_sel);
    msb         = width_msb(width_sel);
    a_m         = opa & mask;
    b_m         = opb & mask;
    op_is_arith = (op_sel == OPC_ADD) || (op_sel == OPC_SUB);
    op_is_logic = (op_sel == OPC_AND) || (op_sel == OPC_OR) || (op_sel == OPC_XOR);
    op_valid    = op_is_arith || op_is_logic;
    flag_load   = en && op_valid;
  end

  mwalu_adder #(.W(DW)) u_add (
    .a_m(a_m), .b_m(b_m), .mask(mask), .msb(msb),
    .sub(op_sel == OPC_SUB),
    .sum(add_y), .cy(add_c), .ov(add_o), .ax(add_a)
  );

  mwalu_logic #(.W(DW)) u_log (
    .op(op_sel), .a_m(a_m), .b_m(b_m), .y(log_y)
  );

  always_comb begin
    if (op_is_arith)      res = add_y;
    else if (op_is_logic) res = log_y;
    else                  res = '0;
    res_msb  = res[msb];
    res_zero = (res == '0);
    nxt_flags        = '0;
    nxt_flags[FB_C]  = op_is_arith & add_c;
    nxt_flags[FB_O]  = op_is_arith & add_o;
    nxt_flags[FB_A]  = op_is_arith & add_a;
    nxt_flags[FB_S]  = res_msb;
    nxt_flags[FB_Z]  = res_zero;
    nxt_flags[FB_P]  = even_par8(res[7:0]);
  end

  mwalu_flagreg #(.N(NFLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .load(flag_load), .d(nxt_flags), .q(stat)
  );

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res & ~mask) == '0);

  // R11
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_load && op_is_logic) |=> (!stat[FB_C] && !stat[FB_O] && !stat[FB_A]));

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (stat[FB_Z] == ($past(res) == '0)));

  // R10
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_load |=> (stat[FB_P] == ($countones($past(res[7:0])) % 2 == 0)));

  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (res == '0));
endmodule

// File: tb/mw_alu_flags_tb_top.sv
module mw_alu_flags_tb_top;
  typedef struct {
    logic [31:0] exp_res;
    logic [5:0]  exp_stat;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic [1:0]  width_sel = 2'd0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] res;
  logic [5:0]  stat;

  int          n_chk = 0, n_fail = 0;
  item_t       sbq[$];
  logic [5:0]  model_stat = '0;
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mw_alu_flags dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .op_sel(op_sel), .width_sel(width_sel),
    .opa(opa), .opb(opb), .res(res), .stat(stat)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // independent reference: 64-bit arithmetic with explicit width
  task automatic drive(input string tag, input logic [2:0] op, input logic [1:0] ws,
                       input logic [31:0] a, input logic [31:0] b, input logic e);
    item_t       it;
    int          w;
    logic [63:0] m, am, bm, r, f, hb;
    logic        c, o, x, ok;
    @(negedge clk);
    w  = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    m  = (64'd1 << w) - 64'd1;
    hb = 64'd1 << (w - 1);
    am = {32'd0, a} & m;
    bm = {32'd0, b} & m;
    c = 1'b0; o = 1'b0; x = 1'b0; ok = 1'b1; r = '0;
    case (op)
      3'd0: begin
        f = am + bm; r = f & m; c = ((f >> w) & 64'd1) != 0;
        x = ((am & 64'hF) + (bm & 64'hF)) > 64'hF;
        o = ((am & hb) == (bm & hb)) && ((r & hb) != (am & hb));
      end
      3'd1: begin
        r = (am - bm) & m; c = am < bm;
        x = (am & 64'hF) < (bm & 64'hF);
        o = ((am & hb) != (bm & hb)) && ((r & hb) != (am & hb));
      end
      3'd2: r = am & bm;
      3'd3: r = am | bm;
      3'd4: r = am ^ bm;
      default: begin r = '0; ok = 1'b0; end
    endcase
    if (e && ok)
      model_stat = {o, (r & hb) != 0, r == 0, x, ($countones(r[7:0]) % 2) == 0, c};
    op_sel = op; width_sel = ws; opa = a; opb = b; en = e;
    it.exp_res = r[31:0]; it.exp_stat = model_stat; it.tag = tag;
    sbq.push_back(it);
  endtask

  // monitor: result still valid after the edge, flags just loaded
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check({it.tag, " res"}, res, it.exp_res);
        check({it.tag, " stat"}, {26'd0, stat}, {26'd0, it.exp_stat});
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R13 reset stat", {26'd0, stat}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1 R5 R8 R9 R10: 8-bit wrap with junk in upper bits
    drive("R1 R5 R8 R9 add8 wrap", 3'd0, 2'd0, 32'hABCD_00FF, 32'h5555_0001, 1'b1);
    // R6 R7: signed overflow at 8 bits
    drive("R6 R7 add8 ovf", 3'd0, 2'd0, 32'hFFFF_FF7F, 32'h0000_0001, 1'b1);
    // R2 R5 R9: borrow
    drive("R2 R5 R9 sub8 borrow", 3'd1, 2'd0, 32'h1234_5600, 32'h0000_0001, 1'b1);
    drive("R2 R6 sub8 ovf", 3'd1, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b1);
    drive("R1 R4 add16 wrap", 3'd0, 2'd1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    drive("R2 R6 sub16 ovf", 3'd1, 2'd1, 32'h0000_8000, 32'h0000_0001, 1'b1);
    // R10: parity uses low byte only
    drive("R10 par16 low byte", 3'd0, 2'd1, 32'h0000_00FF, 32'h0000_0001, 1'b1);
    drive("R1 R5 add32 carry", 3'd0, 2'd2, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1);
    drive("R6 add32 ovf", 3'd0, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1'b1);
    drive("R4 width3 sub32", 3'd1, 2'd3, 32'h0000_0000, 32'h0000_0001, 1'b1);
    // R3 R11: logic ops after carry is set
    drive("R3 R11 and8", 3'd2, 2'd0, 32'hFFFF_F0F3, 32'hFFFF_0F3F, 1'b1);
    drive("R5 set carry", 3'd0, 2'd0, 32'h0000_00F8, 32'h0000_0018, 1'b1);
    drive("R3 R11 or16", 3'd3, 2'd1, 32'h1111_8000, 32'h2222_0001, 1'b1);
    drive("R5 set carry again", 3'd1, 2'd2, 32'h0000_0001, 32'h0000_0010, 1'b1);
    drive("R3 R11 xor32", 3'd4, 2'd2, 32'hF0F0_F0F0, 32'hFFFF_0000, 1'b1);
    // R12: disabled and undefined operations hold flags
    drive("R5 carry before hold", 3'd0, 2'd0, 32'h0000_00FF, 32'h0000_00FF, 1'b1);
    drive("R12 en low", 3'd0, 2'd0, 32'h0000_0001, 32'h0000_0001, 1'b0);
    drive("R12 bad op 5", 3'd5, 2'd2, 32'h0000_0001, 32'h0000_0001, 1'b1);
    drive("R12 bad op 7", 3'd7, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    drive("R13 after hold", 3'd2, 2'd0, 32'h0000_0000, 32'h0000_0000, 1'b1);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] ra, rb;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      ra = seed;
      seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
      rb = seed;
      drive("R1 R2 R3 R7 random", 3'(seed[2:0] % 5), seed[9:8], ra, rb, seed[12] | seed[13]);
    end
    @(negedge clk); en = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule